// File: doc/BRIEF.md
# Power-Up Sequence Controller

This block sequences the start of a low-power radio front end after power-on or reset. Its timebase is a single-cycle enable pulse from a 32 kHz RC oscillator. After reset it opens the gate for the clock-output pin at once, so that an external controller can configure the device. After a fixed number of ticks it flags that output clock as valid. It then holds the analog enables (the normal-operation flag) off until the device has been activated. The device must then stay activated for a full settling interval.

The active-high power-down pin chooses the start-up path. If the pin is low, settling begins on the first tick. If it is high, the block waits in the clock-output phase until the pin is pulled low. A flag records that the first full activation has been completed, and only reset clears it. After that, power-down and wake cycles skip the settling interval.

State machine states, all changing only on a tick:

- `ST_CLKOUT`: waiting for the first activation. The clock output is on.
  - Transition *activate*: pin low, go to `ST_SETTLE`.
- `ST_SETTLE`: counting the settling interval.
  - Transition *abort*: pin high, go to `ST_CLKOUT`, and the count is cleared.
  - Transition *settled*: the last settling tick with the pin low, go to `ST_RUN`, and the first-activation flag is set.
- `ST_RUN`: normal operation.
  - Transition *sleep*: pin high, go to `ST_SLEEP`.
- `ST_SLEEP`: powered down after the first activation. The clock gate and all enables are off.
  - Transition *wake*: pin low, go to `ST_RUN`.

Top module: `pup_seq_ctrl`

## Requirements
- R1: After reset `clk_out_en` is 1, `clk_valid` is 0 and `norm_op` is 0.
- R2: `clk_valid` goes to 1 after the CLKV_TICKS-th tick following reset (default 17). It is still 0 after CLKV_TICKS-1 ticks, and it stays 1 afterwards except in the sleep state.
- R3: While the power-down pin stays high after reset, `norm_op` stays 0 and `clk_out_en` stays 1 for any number of ticks.
- R4: The first tick with the pin low starts settling. `norm_op` becomes 1 after exactly SETTLE_TICKS further ticks with the pin low, and not before.
- R5: A tick with the pin high during settling abandons the count. The next activation needs the full SETTLE_TICKS again.
- R6: In normal operation, a tick with the pin high drives `norm_op`, `clk_out_en` and `clk_valid` to 0.
- R7: After the first completed activation, a tick with the pin low in the sleep state returns `norm_op` to 1 at once, with no settling interval.
- R8: A reset after normal operation restores the R1 outputs and clears the first-activation flag, so a full settling interval is needed again.
- R9: Pin changes between ticks have no effect. Outputs change only in the clock cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock carrying the tick domain |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the 32 kHz timebase |
| pwr_down | input | 1 | Power-down pin, high = powered down |
| clk_out_en | output | 1 | Gate for the clock-output pin |
| clk_valid | output | 1 | Output clock is valid |
| norm_op | output | 1 | Normal-operation timing active (analog enables) |

## Verification
The hardest situation to reach is an abandoned settling count, because the settling interval has to start and then be interrupted part-way. The stimulus activates the device, lets ten ticks pass, and raises the pin for one tick. It then lowers the pin and counts the full interval again, confirming that `norm_op` is still low one tick before the full count. A second scenario enters sleep, so that the wake path can be told apart from a fresh settle. It then resets and checks that settling is required once more.

// File: rtl/pup_pkg.sv
package pup_pkg;

    typedef enum logic [1:0] {
        ST_CLKOUT = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_SLEEP  = 2'd3
    } pup_state_e;

endpackage

// File: rtl/pup_tick_counter.sv
module pup_tick_counter #(
    parameter int LIMIT = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LIM_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_V);
    assign done = (cnt_q == LIM_V);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM_V);

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);

endmodule

// File: rtl/pup_first_flag.sv
module pup_first_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic first_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            first_done <= 1'b0;
        end else if (set) begin
            first_done <= 1'b1;
        end
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        first_done |=> first_done);

endmodule

// File: rtl/pup_seq_ctrl.sv
module pup_seq_ctrl
    import pup_pkg::*;
#(
    parameter int CLKV_TICKS   = 17,
    parameter int SETTLE_TICKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pwr_down,
    output logic clk_out_en,
    output logic clk_valid,
    output logic norm_op
);
    pup_state_e state_q, state_d;
    logic       valid_done;
    logic       valid_last_unused;
    logic       settle_last;
    logic       settle_done_unused;
    logic       first_done;
    logic       settle_inc;
    logic       settle_clr;
    logic       settled;

    assign settle_inc = tick && (state_q == ST_SETTLE) && !pwr_down;
    assign settle_clr = (state_q != ST_SETTLE);
    assign settled    = settle_inc && settle_last;

    pup_tick_counter #(.LIMIT(CLKV_TICKS)) valid_cnt_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (1'b0),
        .inc  (tick),
        .last (valid_last_unused),
        .done (valid_done)
    );

    pup_tick_counter #(.LIMIT(SETTLE_TICKS)) settle_cnt_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (settle_clr),
        .inc  (settle_inc),
        .last (settle_last),
        .done (settle_done_unused)
    );

    pup_first_flag first_i (
        .clk        (clk),
        .rst        (rst),
        .set        (settled),
        .first_done (first_done)
    );

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_CLKOUT: if (!pwr_down) state_d = ST_SETTLE;
                ST_SETTLE: begin
                    if (pwr_down)         state_d = ST_CLKOUT;
                    else if (settle_last) state_d = ST_RUN;
                end
                ST_RUN:    if (pwr_down)  state_d = ST_SLEEP;
                ST_SLEEP:  if (!pwr_down) state_d = ST_RUN;
                default:                  state_d = ST_CLKOUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLKOUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        clk_out_en = 1'b1;
        norm_op    = 1'b0;
        unique case (state_q)
            ST_CLKOUT: ;
            ST_SETTLE: ;
            ST_RUN:    norm_op    = 1'b1;
            ST_SLEEP:  clk_out_en = 1'b0;
            default:   ;
        endcase
        clk_valid = valid_done && clk_out_en;
    end

    // R4
    run_needs_first_chk: assert property (@(posedge clk) disable iff (rst)
        norm_op |-> first_done);

    // R5
    settle_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && tick && pwr_down) |=> (state_q == ST_CLKOUT && !norm_op));

    // R6
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && tick && pwr_down) |=> (!norm_op && !clk_out_en && !clk_valid));

    // R7
    wake_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && tick && !pwr_down) |=> norm_op);

    // R8
    sleep_needs_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP) |-> first_done);

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_q));

endmodule

// File: tb/pup_seq_ctrl_tb.sv
module pup_seq_ctrl_tb_top;
    localparam int CLKV   = 17;
    localparam int SETTLE = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic pwr_down = 1'b1;
    logic clk_out_en, clk_valid, norm_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pup_seq_ctrl #(.CLKV_TICKS(CLKV), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pwr_down   (pwr_down),
        .clk_out_en (clk_out_en),
        .clk_valid  (clk_valid),
        .norm_op    (norm_op)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        pwr_down = pin;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        check("R1", "clk_out_en", clk_out_en, 1'b1);
        check("R1", "clk_valid", clk_valid, 1'b0);
        check("R1", "norm_op", norm_op, 1'b0);
    endtask

    task automatic t_clk_valid;
        do_reset(1'b1);
        do_ticks(CLKV - 1);
        check("R2", "clk_valid before limit", clk_valid, 1'b0);
        do_ticks(1);
        check("R2", "clk_valid at limit", clk_valid, 1'b1);
        do_ticks(60);
        check("R3", "norm_op held off", norm_op, 1'b0);
        check("R3", "clk_out_en kept", clk_out_en, 1'b1);
        check("R2", "clk_valid kept", clk_valid, 1'b1);
    endtask

    task automatic t_settle;
        do_ticks(1);
        pwr_down = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", "no change without tick", norm_op, 1'b0);
        do_ticks(1);
        do_ticks(SETTLE - 1);
        check("R4", "norm_op one tick early", norm_op, 1'b0);
        do_ticks(1);
        check("R4", "norm_op after settle", norm_op, 1'b1);
    endtask

    task automatic t_abort;
        do_reset(1'b0);
        do_ticks(1);
        do_ticks(10);
        pwr_down = 1'b1;
        do_ticks(1);
        check("R5", "norm_op after abort", norm_op, 1'b0);
        pwr_down = 1'b0;
        do_ticks(1);
        do_ticks(SETTLE - 1);
        check("R5", "count restarted", norm_op, 1'b0);
        do_ticks(1);
        check("R5", "norm_op after full recount", norm_op, 1'b1);
    endtask

    task automatic t_sleep_wake;
        pwr_down = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "run held without tick", norm_op, 1'b1);
        do_ticks(1);
        check("R6", "norm_op in sleep", norm_op, 1'b0);
        check("R6", "clk_out_en in sleep", clk_out_en, 1'b0);
        check("R6", "clk_valid in sleep", clk_valid, 1'b0);
        pwr_down = 1'b0;
        do_ticks(1);
        check("R7", "norm_op on wake", norm_op, 1'b1);
        check("R7", "clk_valid on wake", clk_valid, 1'b1);
    endtask

    task automatic t_rereset;
        do_reset(1'b0);
        check("R8", "clk_out_en", clk_out_en, 1'b1);
        check("R8", "clk_valid", clk_valid, 1'b0);
        check("R8", "norm_op", norm_op, 1'b0);
        do_ticks(1);
        do_ticks(SETTLE - 1);
        check("R8", "settle needed again", norm_op, 1'b0);
        do_ticks(1);
        check("R8", "norm_op after settle", norm_op, 1'b1);
    endtask

    initial begin
        t_reset();
        t_clk_valid();
        t_settle();
        t_abort();
        t_sleep_wake();
        t_rereset();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule